// File: doc/BRIEF.md
# Configurable Column Driver Shift-Latch

This block is the digital front end of a display column driver with 192 output bits. On every rising edge of the shift clock a 6-bit word is taken from a parallel bus and pushed into shift chains that work side by side. Two static select pins arrange the 192 cells either as six 32-cell chains, as three 64-cell chains fed from the lower three bus bits, or as two groups of three 32-cell chains. A direction pin picks the end of each chain where new data enters.

An active-low strobe moves the chain contents to the column outputs. While the strobe is low, the outputs follow the chains. When the strobe is high, the outputs keep the value they last took, and the chains are free to load the next line. The shift clock keeps running and the chains shift on every edge. A load is therefore framed by the bus source, which presents one word per edge and drops the strobe during the last word.

Top module: `cdl_column_shift_latch`

## Requirements
- R1: A low level on `rst_n` at a rising clock edge clears every chain cell and every column output to 0 (synchronous, active-low).
- R2: The arrangement is selected by {`bs2`,`bs1`}: 2'b00 gives six 32-cell chains, 2'b01 gives three 64-cell chains, 2'b11 gives two groups of three 32-cell chains, and 2'b10 is a reserved mode.
- R3: With 32-cell chains and `dir`=0, bus bit `db[k]` enters cell 32*k and moves one cell toward higher numbers per edge. After 32 words, cell 32*k+p holds bit k of word 31-p.
- R4: With `dir`=1 the order is reversed. Bus bit `db[k]` enters cell 32*k+31 and moves toward lower cells, so after 32 words cell 32*k+p holds bit k of word p.
- R5: In the three-chain mode, chain k (k=0..2) covers cells 64*k to 64*k+63 and is fed by `db[k]`. Entry and movement follow R3/R4, with a chain length of 64. Bits `db[5:3]` have no effect on any cell or output.
- R6: In the two-group mode, `db[0..2]` feed the 32-cell chains covering outputs 0 to 95 and `db[3..5]` feed those covering outputs 96 to 191. All six chains shift on the same edge.
- R7: The reserved mode 2'b10 loads exactly as the six-chain mode does.
- R8: At a rising edge where `stb_n` is 0, the column outputs take the chain contents produced by that same edge.
- R9: At a rising edge where `stb_n` is 1, the column outputs keep their value while the chains go on shifting.
- R10: Each rising edge advances every chain by exactly one cell. After n < L words loaded from a cleared state, the cells not yet reached still read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; chains advance on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bs1 | input | 1 | Arrangement select, low bit |
| bs2 | input | 1 | Arrangement select, high bit |
| dir | input | 1 | Entry end select: 0 = low cell first, 1 = high cell first |
| db | input | 6 | Parallel data bus, one bit per chain |
| stb_n | input | 1 | Active-low strobe; outputs follow chains while low |
| col_out | output | 192 | Column output bits |

## Verification
A wrong link between two 32-cell segments shows up as a misplaced bit pattern at the outputs on the first strobe after a full line has been loaded. Every scenario therefore loads a line with a distinct pattern, so each wrong link gives a different pattern at the outputs. A latch that fails to hold shows up one edge after the strobe rises, because the chains keep moving. A chain that shifts the wrong way shows up at the outputs one edge after the first word enters. Partial loads check that the cells the data has not reached still read zero.

// File: rtl/cdl_pkg.sv
// Package: shared types of the column shift-latch.
// Assumes the select pins are static during a line load.
package cdl_pkg;

    // Arrangement codes, indexed by {bs2, bs1}.
    typedef enum logic [1:0] {
        MODE_SIX   = 2'b00,
        MODE_WIDE  = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_SPLIT = 2'b11
    } cdl_mode_e;

    // True when neighbouring segments are joined into one long chain.
    function automatic logic joins_pairs(input cdl_mode_e m);
        return (m == MODE_WIDE);
    endfunction

endpackage

// File: rtl/cdl_mode_decode.sv
// Module: turns the two select pins into the segment-joining control.
// Assumes bs1/bs2 are static; the decode is purely combinational.
// The reserved and two-group codes both keep segments separate.
module cdl_mode_decode
    import cdl_pkg::*;
(
    input  logic bs1,
    input  logic bs2,
    output logic wide
);

    cdl_mode_e mode;

    // Purpose: form the mode code and derive the pairing control.
    always_comb begin
        mode = cdl_mode_e'({bs2, bs1});
        wide = joins_pairs(mode);
    end

endmodule

// File: rtl/cdl_segment.sv
// Module: one segment of SEG_LEN shift cells.
// Assumes SEG_LEN >= 2. dir=0 enters at cell 0 and moves up;
// dir=1 enters at cell SEG_LEN-1 and moves down. nxt is the value
// the cells take at the next edge, for the output latch.
module cdl_segment #(
    parameter int SEG_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir,
    input  logic               sin,
    output logic [SEG_LEN-1:0] q,
    output logic [SEG_LEN-1:0] nxt
);

    // Purpose: compute the shifted contents for either direction.
    always_comb begin
        if (dir) begin
            nxt = {sin, q[SEG_LEN-1:1]};
        end else begin
            nxt = {q[SEG_LEN-2:0], sin};
        end
    end

    // Purpose: advance the segment by one cell per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/cdl_lane_router.sv
// Module: picks the serial input of each segment.
// Assumes LANES is even. In pair mode, segments 2k and 2k+1 form one
// chain fed by db[k]; otherwise segment s is fed by db[s].
module cdl_lane_router #(
    parameter int LANES = 6
) (
    input  logic             wide,
    input  logic             dir,
    input  logic [LANES-1:0] db,
    input  logic [LANES-1:0] seg_lo,
    input  logic [LANES-1:0] seg_hi,
    output logic [LANES-1:0] seg_in
);

    for (genvar s = 0; s < LANES; s++) begin : g_route
        localparam int PAIR = s / 2;
        if ((s % 2) == 0) begin : g_even
            // Purpose: lower half of a pair takes the bus or the upper tail.
            always_comb begin
                if (!wide) begin
                    seg_in[s] = db[s];
                end else if (dir) begin
                    seg_in[s] = seg_lo[s+1];
                end else begin
                    seg_in[s] = db[PAIR];
                end
            end
        end else begin : g_odd
            // Purpose: upper half of a pair takes the bus or the lower head.
            always_comb begin
                if (!wide) begin
                    seg_in[s] = db[s];
                end else if (dir) begin
                    seg_in[s] = db[PAIR];
                end else begin
                    seg_in[s] = seg_hi[s-1];
                end
            end
        end
    end

endmodule

// File: rtl/cdl_out_latch.sv
// Module: output holding stage, sampled on the shift clock.
// Assumes open_n is the active-low strobe. While it is low, q takes the
// chain value of the same edge; while it is high, q holds.
module cdl_out_latch #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: follow the chains while open, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!open_n) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cdl_column_shift_latch.sv
// Module: top of the column shift-latch. LANES segments of SEG_LEN
// cells, joined in pairs in the wide mode, feed the output latch.
// Assumes the select pins and dir are static during a line load.
module cdl_column_shift_latch #(
    parameter  int LANES   = 6,
    parameter  int SEG_LEN = 32,
    localparam int COLS    = LANES * SEG_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bs1,
    input  logic             bs2,
    input  logic             dir,
    input  logic [LANES-1:0] db,
    input  logic             stb_n,
    output logic [COLS-1:0]  col_out
);

    logic             wide;
    logic [LANES-1:0] seg_in;
    logic [LANES-1:0] seg_lo;
    logic [LANES-1:0] seg_hi;
    logic [COLS-1:0]  chain_q;
    logic [COLS-1:0]  chain_d;

    cdl_mode_decode u_dec (
        .bs1  (bs1),
        .bs2  (bs2),
        .wide (wide)
    );

    cdl_lane_router #(.LANES(LANES)) u_route (
        .wide   (wide),
        .dir    (dir),
        .db     (db),
        .seg_lo (seg_lo),
        .seg_hi (seg_hi),
        .seg_in (seg_in)
    );

    for (genvar s = 0; s < LANES; s++) begin : g_seg
        cdl_segment #(.SEG_LEN(SEG_LEN)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .dir   (dir),
            .sin   (seg_in[s]),
            .q     (chain_q[s*SEG_LEN +: SEG_LEN]),
            .nxt   (chain_d[s*SEG_LEN +: SEG_LEN])
        );
        assign seg_lo[s] = chain_q[s*SEG_LEN];
        assign seg_hi[s] = chain_q[s*SEG_LEN + SEG_LEN - 1];
    end

    cdl_out_latch #(.WIDTH(COLS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_n (stb_n),
        .d      (chain_d),
        .q      (col_out)
    );

endmodule

// File: rtl/cdl_shift_latch_chk.sv
// Module: assertion checker, bound to the top module.
// Assumes the chain state is brought in through the bind.
module cdl_shift_latch_chk #(
    parameter  int LANES   = 6,
    parameter  int SEG_LEN = 32,
    localparam int COLS    = LANES * SEG_LEN
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bs1,
    input logic            bs2,
    input logic            dir,
    input logic            db_first,
    input logic            db_last,
    input logic            stb_n,
    input logic [COLS-1:0] col_out,
    input logic [COLS-1:0] chain
);

    logic wide_sel;
    assign wide_sel = bs1 && !bs2;

    // R8: an open strobe makes the outputs equal the chains after the edge
    a_r8_follow_chain: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |=> (col_out == chain));

    // R9: a closed strobe keeps the outputs unchanged
    a_r9_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n |=> $stable(col_out));

    // R3: low-first entry of bus bit 0 at cell 0
    a_r3_low_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_sel && !dir) |=> (chain[0] == $past(db_first)));

    // R4: high-first entry of the last bus bit at the top cell
    a_r4_high_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_sel && dir) |=> (chain[COLS-1] == $past(db_last)));

    // R5: in the wide mode, the first pair carries data across the seam upward
    a_r5_seam_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_sel && !dir) |=> (chain[SEG_LEN] == $past(chain[SEG_LEN-1])));

    // R5: and downward when the direction is reversed
    a_r5_seam_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_sel && dir) |=> (chain[SEG_LEN-1] == $past(chain[SEG_LEN])));

endmodule

bind cdl_column_shift_latch cdl_shift_latch_chk #(
    .LANES   (LANES),
    .SEG_LEN (SEG_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bs1      (bs1),
    .bs2      (bs2),
    .dir      (dir),
    .db_first (db[0]),
    .db_last  (db[LANES-1]),
    .stb_n    (stb_n),
    .col_out  (col_out),
    .chain    (chain_q)
);

// File: tb/tb_cdl_column_shift_latch.sv
module tb_cdl_column_shift_latch;

    localparam int LANES = 6;
    localparam int SEG   = 32;
    localparam int W     = LANES * SEG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bs1 = 1'b0;
    logic             bs2 = 1'b0;
    logic             dir = 1'b0;
    logic [LANES-1:0] db = '0;
    logic             stb_n = 1'b1;
    logic [W-1:0]     col_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [LANES-1:0] words [64];

    always #4 clk = ~clk;

    cdl_column_shift_latch dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bs1     (bs1),
        .bs2     (bs2),
        .dir     (dir),
        .db      (db),
        .stb_n   (stb_n),
        .col_out (col_out)
    );

    function automatic logic [LANES-1:0] mkword(input int i, input int seed);
        logic [31:0] h;
        h = (32'(i) * 32'h9E3779B1) ^ (32'(seed) * 32'h0000_9E37) ^ 32'h5A5A_1234;
        h = h ^ (h >> 13);
        h = h * 32'h0001_0DCD;
        return h[LANES-1:0] ^ h[21:16];
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) words[i] = mkword(i, seed);
    endtask

    // Expected outputs after n words into chains of length len.
    function automatic logic [W-1:0] expect_load(input int len, input int n, input logic d);
        logic [W-1:0] e;
        int idx;
        e = '0;
        for (int c = 0; c < W / len; c++) begin
            for (int p = 0; p < len; p++) begin
                if (!d) idx = (p < n) ? (n - 1 - p) : -1;
                else    idx = (p >= len - n) ? (p - (len - n)) : -1;
                if (idx >= 0) e[c*len + p] = words[idx][c];
            end
        end
        return e;
    endfunction

    task automatic check_vec(input logic [W-1:0] exp, input string tag);
        checks++;
        if (col_out !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, col_out, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stb_n = 1'b1;
        db    = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [LANES-1:0] w, input logic strobe);
        db    = w;
        stb_n = ~strobe;
        @(posedge clk);
        @(negedge clk);
        stb_n = 1'b1;
    endtask

    // Load n words from a cleared state, strobe on the last one, check.
    task automatic load_line(input logic b2, input logic b1, input logic d,
                             input int len, input int n, input int seed,
                             input string tag);
        fill(seed);
        bs2 = b2;
        bs1 = b1;
        dir = d;
        do_reset();
        for (int i = 0; i < n; i++) push(words[i], i == n - 1);
        check_vec(expect_load(len, n, d), tag);
    endtask

    // R9: chains keep moving with the strobe high; outputs must hold.
    task automatic hold_check(input string tag);
        logic [W-1:0] snap;
        snap = col_out;
        for (int i = 0; i < 5; i++) push(~words[i], 1'b0);
        check_vec(snap, tag);
    endtask

    task automatic t_reset_state();
        do_reset();
        check_vec('0, "R1 reset state");
    endtask

    task automatic t_six_low();
        load_line(1'b0, 1'b0, 1'b0, 32, 32, 11, "R2 R3 six chains low-first");
        hold_check("R9 hold after six-chain load");
    endtask

    task automatic t_six_high();
        load_line(1'b0, 1'b0, 1'b1, 32, 32, 23, "R4 six chains high-first");
        hold_check("R9 hold after high-first load");
    endtask

    task automatic t_wide_low();
        load_line(1'b0, 1'b1, 1'b0, 64, 64, 37, "R5 three chains low-first");
        hold_check("R9 hold after wide load");
    endtask

    task automatic t_wide_high();
        load_line(1'b0, 1'b1, 1'b1, 64, 64, 41, "R5 three chains high-first");
    endtask

    // R5: same low bits, flipped upper bits, must give identical outputs.
    task automatic t_wide_ignore();
        logic [W-1:0] first;
        load_line(1'b0, 1'b1, 1'b0, 64, 64, 53, "R5 wide reference load");
        first = col_out;
        do_reset();
        for (int i = 0; i < 64; i++) push(words[i] ^ 6'b111000, i == 63);
        check_vec(first, "R5 upper bus bits ignored");
    endtask

    task automatic t_split();
        load_line(1'b1, 1'b1, 1'b0, 32, 32, 67, "R6 two groups low-first");
        load_line(1'b1, 1'b1, 1'b1, 32, 32, 71, "R6 two groups high-first");
    endtask

    task automatic t_reserved();
        load_line(1'b1, 1'b0, 1'b0, 32, 32, 83, "R7 reserved mode as six chains");
        load_line(1'b1, 1'b0, 1'b1, 32, 32, 89, "R7 reserved mode reversed");
    endtask

    task automatic t_partial();
        load_line(1'b0, 1'b0, 1'b0, 32, 9, 97, "R10 partial six-chain low-first");
        load_line(1'b0, 1'b1, 1'b1, 64, 40, 101, "R10 partial wide high-first");
    endtask

    // R8: a strobe held low for several edges tracks every edge.
    task automatic t_follow();
        fill(113);
        bs2 = 1'b0;
        bs1 = 1'b0;
        dir = 1'b0;
        do_reset();
        for (int i = 0; i < 3; i++) push(words[i], 1'b1);
        check_vec(expect_load(32, 3, 1'b0), "R8 outputs follow after 3 words");
        push(words[3], 1'b1);
        check_vec(expect_load(32, 4, 1'b0), "R8 outputs follow after 4 words");
    endtask

    task automatic t_reset_after_load();
        load_line(1'b0, 1'b0, 1'b1, 32, 32, 127, "R4 load before reset");
        do_reset();
        check_vec('0, "R1 reset clears loaded outputs");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_six_low();
        t_six_high();
        t_wide_low();
        t_wide_high();
        t_wide_ignore();
        t_split();
        t_reserved();
        t_partial();
        t_follow();
        t_reset_after_load();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule